// File: doc/BRIEF.md
# Three-Stage Pipeline Operand Bypass

This block resolves read-after-write data hazards in a three-stage integer pipeline. The three stages are instruction fetch, execute and data-memory access. It works within a single cycle. Each source register number of the instruction now in execute is compared with the destination of the instruction one slot ahead, in the memory stage. For each operand, the block then chooses between two values: the register-file read value, or the ALU result that the memory-stage pipeline register still holds. Every operand has its own comparator, so any number of operands (two by default) can take the bypass in the same cycle.

The block never holds the pipeline back and has no stall or bubble output. A load in the memory stage is never forwarded, because the pipeline has one architected load delay slot: the instruction right after a load must not depend on the loaded value. A producer two slots ahead needs no bypass. The register file is written at the end of the memory stage and reads return the newly written value. Branches use one architected delay slot, so no flush path exists either. Register 0 is hardwired to zero and is never forwarded. The block holds no state: its outputs follow its inputs in the same cycle.

Top module: `opfwd_unit`

## Requirements
- R1: An operand selects the bypass (select bit 1, operand equal to `m_alu_result`) when all of these hold: its source index equals `m_dst_idx`, `m_wr_en` is 1, `m_is_load` is 0, and `m_dst_idx` is not 0.
- R2: An operand whose source index differs from `m_dst_idx` has select bit 0 and carries its own register-file value unchanged.
- R3: When `m_wr_en` is 0, no operand selects the bypass, even if the indices match.
- R4: When `m_is_load` is 1, no operand selects the bypass, even if the indices match and `m_wr_en` is 1.
- R5: When `m_dst_idx` is 0 (register 0 hardwired to zero), no operand selects the bypass. A source index of 0 therefore always reads the register-file value.
- R6: Each operand is decided on its own. Both operands may select the bypass in the same cycle, and one operand's match never changes the other operand's select or data.
- R7: The block has no clock and no state. Operands and select bits reflect the current inputs without waiting for a clock edge, and there is no stall output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_src_idx | input | NUM_SRC x IDX_W | Source register numbers of the execute-stage instruction, one per operand |
| x_rf_data | input | NUM_SRC x XLEN | Register-file read value for each operand |
| m_dst_idx | input | IDX_W | Destination register number of the memory-stage instruction |
| m_wr_en | input | 1 | Memory-stage instruction writes the register file |
| m_is_load | input | 1 | Memory-stage instruction is a load |
| m_alu_result | input | XLEN | ALU result held in the memory-stage pipeline register |
| x_opnd | output | NUM_SRC x XLEN | Operands delivered to the ALU |
| x_byp_sel | output | NUM_SRC | Per-operand select: 1 for bypass, 0 for register file |

## Verification
Whenever the combinational outputs settle, the assertions check several rules. The data on each operand must agree with its select bit. A select bit may be set only when the indices match. A disabled write, a load, or register 0 must never produce a bypass. Only the bench scenarios can show the complementary direction: a qualified match does set the bypass. The random scenarios confirm that both operands can take the bypass together and that neither disturbs the other. The bench also shows that outputs change between clock edges, with no register on the path.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

   typedef enum logic [0:0] {
      OPSEL_RF  = 1'b0,
      OPSEL_BYP = 1'b1
   } opsel_e;

endpackage

// File: rtl/opfwd_producer_qual.sv
module opfwd_producer_qual #(
   parameter int  IDX_W    = 5,
   parameter bit  ZERO_REG = 1'b1
) (
   input  logic [IDX_W-1:0] m_dst_idx,
   input  logic             m_wr_en,
   input  logic             m_is_load,
   output logic             eligible
);

   logic dst_ok;

   generate
      if (ZERO_REG) begin : g_zero_hardwired
         assign dst_ok = |m_dst_idx;
      end else begin : g_zero_plain
         assign dst_ok = 1'b1;
      end
   endgenerate

   // A load result is not ready in time: the load delay slot covers it.
   assign eligible = m_wr_en & ~m_is_load & dst_ok;

endmodule

// File: rtl/opfwd_src_cmp.sv
module opfwd_src_cmp
   import opfwd_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] src_idx,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic             eligible,
   output opsel_e           sel
);

   always_comb begin
      if (eligible && (src_idx == dst_idx)) sel = OPSEL_BYP;
      else                                  sel = OPSEL_RF;
   end

endmodule

// File: rtl/opfwd_opnd_mux.sv
module opfwd_opnd_mux
   import opfwd_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter bit ANDOR = 1'b1
) (
   input  opsel_e            sel,
   input  logic [XLEN-1:0]   rf_val,
   input  logic [XLEN-1:0]   byp_val,
   output logic [XLEN-1:0]   opnd
);

   logic take_byp;
   assign take_byp = (sel == OPSEL_BYP);

   generate
      if (ANDOR) begin : g_andor
         assign opnd = ({XLEN{take_byp}} & byp_val) | ({XLEN{~take_byp}} & rf_val);
      end else begin : g_ternary
         assign opnd = take_byp ? byp_val : rf_val;
      end
   endgenerate

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
   import opfwd_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NREGS    = 32,
   parameter int NUM_SRC  = 2,
   parameter bit ZERO_REG = 1'b1,
   parameter bit ANDOR    = 1'b1,
   localparam int IDX_W   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic [NUM_SRC-1:0][IDX_W-1:0] x_src_idx,
   input  logic [NUM_SRC-1:0][XLEN-1:0]  x_rf_data,
   input  logic [IDX_W-1:0]              m_dst_idx,
   input  logic                          m_wr_en,
   input  logic                          m_is_load,
   input  logic [XLEN-1:0]               m_alu_result,
   output logic [NUM_SRC-1:0][XLEN-1:0]  x_opnd,
   output logic [NUM_SRC-1:0]            x_byp_sel
);

   generate
      if (XLEN < 1) begin : g_bad_xlen
         $error("opfwd_unit: XLEN must be at least 1");
      end
      if (NREGS < 2) begin : g_bad_nregs
         $error("opfwd_unit: NREGS must be at least 2");
      end
      if (NUM_SRC < 1) begin : g_bad_nsrc
         $error("opfwd_unit: NUM_SRC must be at least 1");
      end
   endgenerate

   logic   eligible;
   opsel_e sel [NUM_SRC];

   opfwd_producer_qual #(
      .IDX_W    (IDX_W),
      .ZERO_REG (ZERO_REG)
   ) qual_i (
      .m_dst_idx (m_dst_idx),
      .m_wr_en   (m_wr_en),
      .m_is_load (m_is_load),
      .eligible  (eligible)
   );

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         opfwd_src_cmp #(.IDX_W(IDX_W)) cmp_i (
            .src_idx  (x_src_idx[s]),
            .dst_idx  (m_dst_idx),
            .eligible (eligible),
            .sel      (sel[s])
         );

         opfwd_opnd_mux #(.XLEN(XLEN), .ANDOR(ANDOR)) mux_i (
            .sel     (sel[s]),
            .rf_val  (x_rf_data[s]),
            .byp_val (m_alu_result),
            .opnd    (x_opnd[s])
         );

         assign x_byp_sel[s] = (sel[s] == OPSEL_BYP);
      end
   endgenerate

   always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
         AST_BYP_DATA: assert (!x_byp_sel[s] || (x_opnd[s] == m_alu_result))
            else $error("bypass selected but operand is not the ALU result"); // R1
         AST_RF_DATA: assert (x_byp_sel[s] || (x_opnd[s] == x_rf_data[s]))
            else $error("register-file path selected but operand differs"); // R2
         AST_SEL_NEEDS_MATCH: assert (!x_byp_sel[s] || (x_src_idx[s] == m_dst_idx))
            else $error("bypass selected without an index match"); // R6
         AST_NO_FWD_WEN: assert (m_wr_en || !x_byp_sel[s])
            else $error("bypass with write enable low"); // R3
         AST_NO_FWD_LOAD: assert (!m_is_load || !x_byp_sel[s])
            else $error("load result forwarded"); // R4
         AST_NO_FWD_ZERO: assert (!ZERO_REG || (m_dst_idx != '0) || !x_byp_sel[s])
            else $error("register 0 forwarded"); // R5
      end
   end

endmodule

// File: tb/opfwd_unit_tb_top.sv
module opfwd_unit_tb_top;

   localparam int XLEN    = 32;
   localparam int NREGS   = 32;
   localparam int NUM_SRC = 2;
   localparam int IDX_W   = $clog2(NREGS);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [NUM_SRC-1:0][IDX_W-1:0] x_src_idx = '0;
   logic [NUM_SRC-1:0][XLEN-1:0]  x_rf_data = '0;
   logic [IDX_W-1:0]              m_dst_idx = '0;
   logic                          m_wr_en   = 1'b0;
   logic                          m_is_load = 1'b0;
   logic [XLEN-1:0]               m_alu_result = '0;
   logic [NUM_SRC-1:0][XLEN-1:0]  x_opnd;
   logic [NUM_SRC-1:0]            x_byp_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   opfwd_unit #(.XLEN(XLEN), .NREGS(NREGS), .NUM_SRC(NUM_SRC)) dut_i (
      .x_src_idx    (x_src_idx),
      .x_rf_data    (x_rf_data),
      .m_dst_idx    (m_dst_idx),
      .m_wr_en      (m_wr_en),
      .m_is_load    (m_is_load),
      .m_alu_result (m_alu_result),
      .x_opnd       (x_opnd),
      .x_byp_sel    (x_byp_sel)
   );

   function automatic bit exp_fwd(input logic [IDX_W-1:0] src, input logic [IDX_W-1:0] dst,
                                  input logic wen, input logic ld);
      return wen && !ld && (dst != '0) && (src == dst);
   endfunction

   task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int s = 0; s < NUM_SRC; s++) begin
         bit f = exp_fwd(x_src_idx[s], m_dst_idx, m_wr_en, m_is_load);
         check(req, {31'd0, x_byp_sel[s]}, {31'd0, f});
         check(req, x_opnd[s], f ? m_alu_result : x_rf_data[s]);
      end
   endtask

   task automatic apply(input string req,
                        input logic [IDX_W-1:0] s0, input logic [IDX_W-1:0] s1,
                        input logic [IDX_W-1:0] d, input logic wen, input logic ld);
      @(negedge clk);
      x_src_idx[0] = s0;
      x_src_idx[1] = s1;
      x_rf_data[0] = $urandom;
      x_rf_data[1] = $urandom;
      m_dst_idx    = d;
      m_wr_en      = wen;
      m_is_load    = ld;
      m_alu_result = $urandom;
      #1;
      check_all(req);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20110222));
      #2;
      // idle state with all-zero inputs: no bypass (R2, R5)
      check("R2 idle sel", {30'd0, x_byp_sel}, 32'd0);
      check("R5 idle opnd", x_opnd[0], 32'd0);

      apply("R1 op0 fwd",        5'd3, 5'd9,  5'd3, 1'b1, 1'b0);
      check("R1 op0 sel",        {30'd0, x_byp_sel}, 32'd1);
      apply("R1 op1 fwd",        5'd4, 5'd17, 5'd17, 1'b1, 1'b0);
      check("R1 op1 sel",        {30'd0, x_byp_sel}, 32'd2);
      apply("R2 no match",       5'd1, 5'd2,  5'd30, 1'b1, 1'b0);
      check("R2 sel",            {30'd0, x_byp_sel}, 32'd0);
      apply("R3 wen low",        5'd6, 5'd6,  5'd6, 1'b0, 1'b0);
      check("R3 sel",            {30'd0, x_byp_sel}, 32'd0);
      apply("R4 load in M",      5'd8, 5'd8,  5'd8, 1'b1, 1'b1);
      check("R4 sel",            {30'd0, x_byp_sel}, 32'd0);
      apply("R5 reg zero",       5'd0, 5'd0,  5'd0, 1'b1, 1'b0);
      check("R5 sel",            {30'd0, x_byp_sel}, 32'd0);
      apply("R6 both fwd",       5'd31, 5'd31, 5'd31, 1'b1, 1'b0);
      check("R6 both sel",       {30'd0, x_byp_sel}, 32'd3);

      // R7: mid-cycle change with no clock edge in between
      @(posedge clk);
      #1;
      m_wr_en = 1'b0;
      #1;
      check("R7 comb drop", {30'd0, x_byp_sel}, 32'd0);
      m_wr_en = 1'b1;
      #1;
      check("R7 comb rise", {30'd0, x_byp_sel}, 32'd3);

      for (int n = 0; n < 400; n++) begin
         logic [IDX_W-1:0] s0 = IDX_W'($urandom_range(0, 3));
         logic [IDX_W-1:0] s1 = IDX_W'($urandom_range(0, 3));
         logic [IDX_W-1:0] d  = IDX_W'($urandom_range(0, 3));
         if ((n % 5) == 0) d = IDX_W'($urandom);
         apply("R6 random", s0, s1, d, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule